// File: doc/BRIEF.md
# Configuration Readback Scrub Sequencer

This block runs one readback pass over the byte-wide parallel configuration port of an SRAM FPGA. The pass starts with a start pulse, a start frame address and a word count. It opens the session with an abort pattern on the port. It then writes a fixed command stream: a dummy word, a sync word, a frame-address packet, a readback command packet, and a frame-data read packet that carries the word count. After that it releases the data bus and collects the returned bytes into 32-bit words until every requested word has arrived.

While the words arrive, a CRC-32 runs over them. An optional word-by-word comparison against an external expected-word source counts the words that differ. When the pass ends, the block compares the CRC with an expected value and raises one of two outcomes. An ordinary CRC mismatch flags a configuration upset. A mismatch count above a programmable limit is taken as a fault in the configuration interface itself, and the block requests a full reconfiguration instead.

The block runs on the configuration clock, with one byte per cycle on the port. All status outputs hold until the next accepted start.

Top module: `cfg_scrub_seq`

## Requirements
- R1: An accepted start opens the session with ABORT_LEN cycles that have chip-select low, the data bus released and the write strobe alternating low, high, low, high. No byte is driven during these cycles. One cycle with chip-select high follows.
- R2: The first eight command bytes are FF FF FF FF, then AA 99 55 66.
- R3: Command bytes 8 to 15 are 30 00 20 01, then the start frame address, most significant byte first.
- R4: Command bytes 16 to 23 are 30 00 80 01, then 00 00 00 04.
- R5: Command bytes 24 to 31 are 28 00 60 00, then the word 0x48000000 OR'd with the word count in bits 26:0. Each command byte occupies one cycle, with chip-select and write strobe low and the output enable high. The output enable is never high otherwise.
- R6: After the last command byte there is one turnaround cycle with the write strobe high and the bus released. Bytes are then captured only in cycles where busy is low. Chip-select stays low until exactly word_count words (4×word_count bytes) have been captured. A start pulse during a session has no effect on it.
- R7: The CRC is CRC-32 with polynomial 0x04C11DB7 and seed 0xFFFFFFFF. Words are fed most significant bit first, with no reflection and no final inversion, and bytes form words most significant byte first. At the end, crc_error is 1 exactly when the CRC differs from exp_crc. A count of zero compares the seed itself.
- R8: When cmp_en is 1, each captured word that differs from exp_word counts as a mismatch. If the count exceeds mismatch_limit, reconfig_request is set and crc_error is forced to 0. A count equal to the limit still gives the normal CRC outcome.
- R9: After reset, chip-select and write strobe are high, the bus is released, and done, crc_error and reconfig_request are 0. done and both flags are set together at the end of a pass and hold until the next accepted start clears them.
- R10: word_index gives the number of words captured so far in the current pass. exp_word must hold the expected value for that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| start_frame_addr | input | 32 | First frame address of the pass |
| word_count | input | WCNT_W | Number of 32-bit words to read back |
| exp_crc | input | 32 | Expected CRC of the readback words |
| cmp_en | input | 1 | Enables word-by-word comparison |
| exp_word | input | 32 | Expected word for index word_index |
| mismatch_limit | input | MCNT_W | Mismatch count allowed before a reconfiguration request |
| cfg_cs_n | output | 1 | Port chip-select, active low |
| cfg_wr_n | output | 1 | Port write strobe, low writes, high reads |
| cfg_data_o | output | 8 | Port data driven during command writes |
| cfg_data_oe | output | 1 | Output enable for cfg_data_o |
| cfg_data_i | input | 8 | Port data returned during readback |
| cfg_busy | input | 1 | Port busy; a byte is valid only when low |
| word_index | output | WCNT_W | Words captured in this pass |
| done | output | 1 | Pass finished |
| crc_error | output | 1 | Configuration upset detected |
| reconfig_request | output | 1 | Interface upset, full reconfiguration needed |

## Verification
The assertions take for granted that start is a single-cycle pulse and that reset is held for at least one clock edge. The bench keeps to this: it drives start for one cycle only and holds reset over several edges. The word-index property also relies on word_index counting up by one per captured word and returning to zero only when a new pass begins. The device model in the bench offers read bytes only once the turnaround cycle has passed, and it holds busy high in every cycle in which it has nothing to offer. It also derives exp_word from word_index at all times, so the comparison input always matches the index the block presents.

// File: rtl/cfg_scrub_pkg.sv
// Package: shared state type, command constants and the CRC step for the
// configuration readback scrub sequencer.
// Assumes: CRC is non-reflected, fed MSB first, no final inversion.
package cfg_scrub_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ABORT,
        ST_GAP,
        ST_CMD,
        ST_TURN,
        ST_READ,
        ST_CHECK
    } scrub_state_t;

    localparam int          CMD_BYTES   = 32;
    localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED    = 32'hFFFF_FFFF;
    localparam logic [31:0] W_DUMMY     = 32'hFFFF_FFFF;
    localparam logic [31:0] W_SYNC      = 32'hAA99_5566;
    localparam logic [31:0] W_HDR_FADDR = 32'h3000_2001;
    localparam logic [31:0] W_HDR_CMD   = 32'h3000_8001;
    localparam logic [31:0] W_RDCFG     = 32'h0000_0004;
    localparam logic [31:0] W_HDR_FREAD = 32'h2800_6000;
    localparam logic [4:0]  CNT_HDR     = 5'b01001;

    // Advance a CRC-32 register by one 32-bit word, MSB first.
    function automatic logic [31:0] crc_step(input logic [31:0] crc_in,
                                             input logic [31:0] word);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 31; i >= 0; i--) begin
            fb = c[31] ^ word[i];
            c  = {c[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
        return c;
    endfunction

endpackage

// File: rtl/cfg_cmd_rom.sv
// Command byte source: maps a byte index 0..31 of the readback command
// stream to the byte to drive. Word-level layout, MSB first within words.
// Assumes: far and cnt_word are stable for the whole command phase.
module cfg_cmd_rom
    import cfg_scrub_pkg::*;
(
    input  logic [4:0]  idx,
    input  logic [31:0] far,
    input  logic [31:0] cnt_word,
    output logic [7:0]  byte_o
);

    logic [31:0] word_sel;

    // Pick the 32-bit command word that holds this byte.
    always_comb begin
        unique case (idx[4:2])
            3'd0:    word_sel = W_DUMMY;
            3'd1:    word_sel = W_SYNC;
            3'd2:    word_sel = W_HDR_FADDR;
            3'd3:    word_sel = far;
            3'd4:    word_sel = W_HDR_CMD;
            3'd5:    word_sel = W_RDCFG;
            3'd6:    word_sel = W_HDR_FREAD;
            default: word_sel = cnt_word;
        endcase
    end

    // Extract the byte, most significant first.
    always_comb begin
        unique case (idx[1:0])
            2'd0:    byte_o = word_sel[31:24];
            2'd1:    byte_o = word_sel[23:16];
            2'd2:    byte_o = word_sel[15:8];
            default: byte_o = word_sel[7:0];
        endcase
    end

endmodule

// File: rtl/cfg_word_asm.sv
// Byte-to-word assembler: collects accepted bytes MSB first into 32-bit
// words and counts completed words.
// Assumes: clear and cap_en are never high in the same cycle.
module cfg_word_asm #(
    parameter int WCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cap_en,
    input  logic [7:0]        byte_i,
    output logic [31:0]       word_o,
    output logic              word_last,
    output logic [WCNT_W-1:0] words
);

    localparam logic [WCNT_W-1:0] ONE_W = WCNT_W'(1);

    logic [23:0] shreg;
    logic [1:0]  bcnt;

    assign word_o    = {shreg, byte_i};
    assign word_last = cap_en && (bcnt == 2'd3);

    // Shift in bytes and track the byte position inside the word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            shreg <= '0;
            bcnt  <= '0;
        end else if (cap_en) begin
            shreg <= {shreg[15:0], byte_i};
            bcnt  <= bcnt + 2'd1;
        end
    end

    // Count words completed in the current pass.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            words <= '0;
        end else if (word_last) begin
            words <= words + ONE_W;
        end
    end

endmodule

// File: rtl/cfg_crc_acc.sv
// CRC-32 accumulator over assembled readback words.
// Assumes: clear re-seeds the register at the start of each pass.
module cfg_crc_acc
    import cfg_scrub_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        upd,
    input  logic [31:0] word_i,
    output logic [31:0] crc_o
);

    // Seed on reset or clear, fold in one word per update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc_o <= CRC_SEED;
        end else if (upd) begin
            crc_o <= crc_step(crc_o, word_i);
        end
    end

endmodule

// File: rtl/cfg_mis_ctr.sv
// Saturating mismatch counter for word-by-word comparison.
// Assumes: differ is only meaningful when upd is high.
module cfg_mis_ctr #(
    parameter int MCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              upd,
    input  logic              differ,
    output logic [MCNT_W-1:0] count
);

    localparam logic [MCNT_W-1:0] CMAX = {MCNT_W{1'b1}};

    // Count differing words, stopping at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (upd && differ && (count != CMAX)) begin
            count <= count + MCNT_W'(1);
        end
    end

endmodule

// File: rtl/cfg_scrub_seq.sv
// Readback scrub sequencer top: aborts, writes the readback command
// stream, drains every requested word, then checks CRC and mismatch count.
// Assumes: clk is the configuration clock; start is a one-cycle pulse;
// word_count fits in 27 bits.
module cfg_scrub_seq
    import cfg_scrub_pkg::*;
#(
    parameter int ABORT_LEN = 4,
    parameter int WCNT_W    = 16,
    parameter int MCNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       start_frame_addr,
    input  logic [WCNT_W-1:0] word_count,
    input  logic [31:0]       exp_crc,
    input  logic              cmp_en,
    input  logic [31:0]       exp_word,
    input  logic [MCNT_W-1:0] mismatch_limit,
    output logic              cfg_cs_n,
    output logic              cfg_wr_n,
    output logic [7:0]        cfg_data_o,
    output logic              cfg_data_oe,
    input  logic [7:0]        cfg_data_i,
    input  logic              cfg_busy,
    output logic [WCNT_W-1:0] word_index,
    output logic              done,
    output logic              crc_error,
    output logic              reconfig_request
);

    localparam int                PC_W     = (ABORT_LEN > 32) ? $clog2(ABORT_LEN) : 5;
    localparam logic [PC_W-1:0]   ABORT_LST = PC_W'(ABORT_LEN - 1);
    localparam logic [PC_W-1:0]   CMD_LST   = PC_W'(CMD_BYTES - 1);
    localparam logic [WCNT_W-1:0] ONE_W     = WCNT_W'(1);

    scrub_state_t      state;
    logic [PC_W-1:0]   phase;
    logic [31:0]       far_q;
    logic [WCNT_W-1:0] cnt_q;
    logic              accept;
    logic              cap_en;
    logic [31:0]       asm_word;
    logic              asm_last;
    logic [WCNT_W-1:0] asm_words;
    logic [31:0]       crc_val;
    logic [MCNT_W-1:0] mis_cnt;
    logic [7:0]        rom_byte;
    logic [31:0]       cnt_word;

    assign accept   = (state == ST_IDLE) && start;
    assign cap_en   = (state == ST_READ) && !cfg_busy;
    assign cnt_word = {CNT_HDR, 27'(cnt_q)};

    cfg_cmd_rom u_rom (
        .idx      (phase[4:0]),
        .far      (far_q),
        .cnt_word (cnt_word),
        .byte_o   (rom_byte)
    );

    cfg_word_asm #(.WCNT_W(WCNT_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .cap_en    (cap_en),
        .byte_i    (cfg_data_i),
        .word_o    (asm_word),
        .word_last (asm_last),
        .words     (asm_words)
    );

    cfg_crc_acc u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .upd    (asm_last),
        .word_i (asm_word),
        .crc_o  (crc_val)
    );

    cfg_mis_ctr #(.MCNT_W(MCNT_W)) u_mis (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .upd    (asm_last && cmp_en),
        .differ (asm_word != exp_word),
        .count  (mis_cnt)
    );

    // Session sequencing: abort, gap, command bytes, turnaround, drain, check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            phase <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    phase <= '0;
                    if (start) state <= ST_ABORT;
                end
                ST_ABORT: begin
                    if (phase == ABORT_LST) begin
                        phase <= '0;
                        state <= ST_GAP;
                    end else begin
                        phase <= phase + PC_W'(1);
                    end
                end
                ST_GAP: state <= ST_CMD;
                ST_CMD: begin
                    if (phase == CMD_LST) begin
                        phase <= '0;
                        state <= ST_TURN;
                    end else begin
                        phase <= phase + PC_W'(1);
                    end
                end
                ST_TURN: state <= (cnt_q == '0) ? ST_CHECK : ST_READ;
                ST_READ: begin
                    if (asm_last && ((asm_words + ONE_W) == cnt_q)) state <= ST_CHECK;
                end
                ST_CHECK: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Latch the pass parameters when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            far_q <= '0;
            cnt_q <= '0;
        end else if (accept) begin
            far_q <= start_frame_addr;
            cnt_q <= word_count;
        end
    end

    // Result flags: cleared on accept, decided once in the check cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            done             <= 1'b0;
            crc_error        <= 1'b0;
            reconfig_request <= 1'b0;
        end else if (state == ST_CHECK) begin
            done <= 1'b1;
            if (cmp_en && (mis_cnt > mismatch_limit)) begin
                reconfig_request <= 1'b1;
            end else begin
                crc_error <= (crc_val != exp_crc);
            end
        end
    end

    // Port pin decode from the current state.
    always_comb begin
        cfg_cs_n    = 1'b1;
        cfg_wr_n    = 1'b1;
        cfg_data_oe = 1'b0;
        cfg_data_o  = 8'h00;
        unique case (state)
            ST_ABORT: begin
                cfg_cs_n = 1'b0;
                cfg_wr_n = phase[0];
            end
            ST_CMD: begin
                cfg_cs_n    = 1'b0;
                cfg_wr_n    = 1'b0;
                cfg_data_oe = 1'b1;
                cfg_data_o  = rom_byte;
            end
            ST_TURN, ST_READ: cfg_cs_n = 1'b0;
            default: ;
        endcase
    end

    assign word_index = asm_words;

endmodule

// File: rtl/cfg_scrub_seq_chk.sv
// Checker for the scrub sequencer port behaviour, bound to the top module.
// Assumes: start is a one-cycle pulse and reset spans at least one edge.
module cfg_scrub_seq_chk #(
    parameter int WCNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              cfg_cs_n,
    input logic              cfg_wr_n,
    input logic              cfg_data_oe,
    input logic [WCNT_W-1:0] word_index,
    input logic              done,
    input logic              crc_error,
    input logic              reconfig_request
);

    p_drive_only_writing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_data_oe |-> (!cfg_cs_n && !cfg_wr_n));

    p_done_port_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cfg_cs_n && !cfg_data_oe));

    p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_error && reconfig_request));

    p_flags_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_error || reconfig_request) |-> done);

    p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_index_steps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (word_index != $past(word_index)) |->
            ((word_index == $past(word_index) + WCNT_W'(1)) || (word_index == '0)));

endmodule

bind cfg_scrub_seq cfg_scrub_seq_chk #(.WCNT_W(WCNT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .start            (start),
    .cfg_cs_n         (cfg_cs_n),
    .cfg_wr_n         (cfg_wr_n),
    .cfg_data_oe      (cfg_data_oe),
    .word_index       (word_index),
    .done             (done),
    .crc_error        (crc_error),
    .reconfig_request (reconfig_request)
);

// File: tb/tb_cfg_scrub_seq.sv
// Bench: sweeps word counts and error patterns, models the port device,
// checks command bytes, abort pattern, drain length and result flags.
module tb_cfg_scrub_seq;

    localparam int ABORT_LEN = 4;
    localparam int WCNT_W    = 16;
    localparam int MCNT_W    = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [31:0]       start_frame_addr;
    logic [WCNT_W-1:0] word_count;
    logic [31:0]       exp_crc;
    logic              cmp_en;
    logic [31:0]       exp_word;
    logic [MCNT_W-1:0] mismatch_limit;
    logic              cfg_cs_n, cfg_wr_n, cfg_data_oe;
    logic [7:0]        cfg_data_o;
    logic [7:0]        cfg_data_i;
    logic              cfg_busy;
    logic [WCNT_W-1:0] word_index;
    logic              done, crc_error, reconfig_request;

    int n_chk  = 0;
    int n_fail = 0;
    int seed   = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    cfg_scrub_seq #(.ABORT_LEN(ABORT_LEN), .WCNT_W(WCNT_W), .MCNT_W(MCNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_frame_addr(start_frame_addr),
        .word_count(word_count), .exp_crc(exp_crc), .cmp_en(cmp_en), .exp_word(exp_word),
        .mismatch_limit(mismatch_limit), .cfg_cs_n(cfg_cs_n), .cfg_wr_n(cfg_wr_n),
        .cfg_data_o(cfg_data_o), .cfg_data_oe(cfg_data_oe), .cfg_data_i(cfg_data_i),
        .cfg_busy(cfg_busy), .word_index(word_index), .done(done), .crc_error(crc_error),
        .reconfig_request(reconfig_request)
    );

    function automatic logic [31:0] gen_word(input int s, input int i);
        return (32'h9E37_79B9 * 32'(i + 1)) ^ (32'h1357_0000 + 32'(s));
    endfunction

    assign exp_word = gen_word(seed, int'(word_index));

    // Reference CRC: bit-serial register, MSB of each word first.
    function automatic logic [31:0] ref_crc(input int s, input int n, input logic [15:0] errs);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int w = 0; w < n; w++) begin
            logic [31:0] d = gen_word(s, w) ^ (errs[w] ? 32'h0004_0000 : 32'h0);
            for (int b = 31; b >= 0; b--) begin
                logic top = c[31] ^ d[b];
                c = c << 1;
                if (top) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One readback pass with an error pattern, optional start poke mid-pass.
    task automatic run(input int n, input logic [15:0] errs, input logic cen,
                       input logic [7:0] lim, input logic bad_crc, input int poke);
        logic [31:0] far   = 32'h0012_0000 + 32'(n * 97) + 32'(seed);
        logic [31:0] cmdw[8];
        logic [7:0]  got[32];
        logic [31:0] good  = ref_crc(seed, n, 16'h0);
        logic [31:0] dev   = ref_crc(seed, n, errs);
        int nbytes = 0, abort_n = 0, rd_ptr = 0, it = 0, nerr = 0;
        bit abort_ok = 1, turn_seen = 0, finished = 0;
        bit exp_rc, exp_ce;
        for (int w = 0; w < n; w++) if (errs[w]) nerr++;
        cmdw = '{32'hFFFF_FFFF, 32'hAA99_5566, 32'h3000_2001, far,
                 32'h3000_8001, 32'h0000_0004, 32'h2800_6000, 32'h4800_0000 | 32'(n)};
        exp_rc = cen && (nerr > int'(lim));
        exp_ce = !exp_rc && ((bad_crc ? ~good : good) != dev);
        @(negedge clk);
        start = 1'b1; start_frame_addr = far; word_count = WCNT_W'(n);
        exp_crc = bad_crc ? ~good : good; cmp_en = cen; mismatch_limit = lim;
        cfg_busy = 1'b1;
        while (!finished && it < 3000) begin
            @(negedge clk);
            it++;
            start = (it == poke);
            if (it == poke) start_frame_addr = ~far;
            cfg_busy = 1'b1;
            if (done) finished = 1;
            else if (!cfg_cs_n && !cfg_wr_n && cfg_data_oe) begin
                if (nbytes < 32) got[nbytes] = cfg_data_o;
                nbytes++;
            end else if (!cfg_cs_n && !cfg_data_oe && nbytes == 0) begin
                if (cfg_wr_n != abort_n[0]) abort_ok = 0;
                abort_n++;
            end else if (!cfg_cs_n && cfg_wr_n && nbytes >= 32) begin
                if (!turn_seen) turn_seen = 1;
                else begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    if (!(lfsr[0] & lfsr[3]) && rd_ptr < 4 * n) begin
                        logic [31:0] d = gen_word(seed, rd_ptr / 4) ^ (errs[rd_ptr / 4] ? 32'h0004_0000 : 32'h0);
                        cfg_busy   = 1'b0;
                        cfg_data_i = d[8 * (3 - rd_ptr % 4) +: 8];
                        rd_ptr++;
                    end
                end
            end
        end
        start = 1'b0;
        chk(finished, "R6 pass completes", 64'(finished), 64'd1);
        chk(abort_ok && abort_n == ABORT_LEN, "R1 abort pattern", 64'(abort_n), 64'(ABORT_LEN));
        chk(nbytes == 32, "R5 command byte count", 64'(nbytes), 64'd32);
        for (int g = 0; g < 4; g++) begin
            bit ok = 1;
            for (int k = 8 * g; k < 8 * g + 8 && k < nbytes; k++)
                if (got[k] !== cmdw[k / 4][8 * (3 - k % 4) +: 8]) ok = 0;
            case (g)
                0: chk(ok, "R2 dummy and sync bytes", 64'(got[0]), 64'hFF);
                1: chk(ok, "R3 frame address packet", 64'(got[12]), 64'(far[31:24]));
                2: chk(ok, "R4 readback command packet", 64'(got[23]), 64'h04);
                default: chk(ok, "R5 read packet and count", 64'(got[31]), 64'(n));
            endcase
        end
        chk(rd_ptr == 4 * n, "R6 bytes drained", 64'(rd_ptr), 64'(4 * n));
        chk(word_index == WCNT_W'(n), "R10 word index", 64'(word_index), 64'(n));
        chk(crc_error == exp_ce, "R7 crc_error", 64'(crc_error), 64'(exp_ce));
        chk(reconfig_request == exp_rc, "R8 reconfig_request", 64'(reconfig_request), 64'(exp_rc));
        if (poke > 0) begin
            bit quiet = 1;
            for (int q = 0; q < 8; q++) begin
                @(negedge clk);
                if (!cfg_cs_n || !done) quiet = 0;
            end
            chk(quiet, "R6 start during pass ignored, R9 done held", 64'(cfg_cs_n), 64'd1);
        end
        seed++;
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; start_frame_addr = '0; word_count = '0;
        exp_crc = '0; cmp_en = 1'b0; mismatch_limit = '0;
        cfg_data_i = 8'h00; cfg_busy = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cfg_cs_n && cfg_wr_n && !cfg_data_oe && !done && !crc_error && !reconfig_request,
            "R9 reset state", {cfg_cs_n, cfg_wr_n, cfg_data_oe, done, crc_error, reconfig_request},
            64'b110000);
        rst_n = 1'b1;
        // Sweep: counts 0..8 crossed with four error patterns, limit 2.
        for (int n = 0; n <= 8; n++) begin
            run(n, 16'h0, 1'b1, 8'd2, 1'b0, 0);
            run(n, 16'(n > 0 ? 1 << (n - 1) : 0), 1'b1, 8'd2, 1'b0, 0);
            run(n, 16'h0003, 1'b1, 8'd2, 1'b0, 0);   // R8 boundary at count 2
            run(n, 16'hFFFF, 1'b1, 8'd2, 1'b0, 0);
        end
        run(0, 16'h0, 1'b1, 8'd2, 1'b1, 0);          // R7 seed compared, wrong expectation
        run(6, 16'hFFFF, 1'b0, 8'd0, 1'b0, 0);       // R8 comparison disabled
        run(5, 16'h0007, 1'b1, 8'd3, 1'b0, 0);       // R8 count equals limit
        run(4, 16'h0, 1'b1, 8'd2, 1'b0, 15);         // R6 start poked mid-command
        run(3, 16'h0, 1'b1, 8'd2, 1'b0, 45);         // R6 start poked in readback
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule